// File: doc/BRIEF.md
# Single-Wire Bus Byte Engine with Interrupt Flags

This block moves bytes between a small host register port and an open-drain single-wire bus. When the host writes a byte to the data address, the byte goes into a one-byte transmit buffer. As soon as the shifter is idle, the byte moves into the transmit shift register. The shifter then sends it bit by bit in fixed time slots paced by an external 1 MHz tick. Each slot also samples the bus. The eight sampled levels form the received byte, which lands in a one-byte receive buffer. To read a byte from a device, the host sends FFh, which leaves the bus free for the device to pull bits low. It sends FFh again for every further byte.

A status register holds the live bus level, an idle indication, the occupancy flags of both transmit stages and the receive buffer, and the flags for a slave interrupt and a finished presence check. The reset/presence sequencer, the long-low detector and the clock divider sit outside this block and report through inputs. Six of the status flags can raise an interrupt line through per-flag enables, and the line's polarity can be selected. A status read drops the line. The line rises again only when another enabled flag is newly set. An enable bit hands the bus to a direct host-controlled level.

Top module: `owm_byte_engine`

## Requirements
- R1: After reset the status register (address 1) reads 4Eh while the bus is held low, the enable register (address 2) reads 00h, and `irq_o` is high (inactive, because polarity bit 1 is 0 and selects active-low).
- R2: A write to the data address (address 0) clears the tx-empty flag (status bit 2). If the shifter is idle and direct mode is off, the byte moves on at the next edge: bit 2 sets again and the shift-empty flag (bit 3) clears.
- R3: A byte written while the shifter is busy waits in the buffer with bit 2 low until the last slot of the current byte ends, and is then loaded.
- R4: Bits go out LSB first. Each slot lasts 70 ticks from its start. The bus is pulled low for the first 6 ticks of a slot that sends 1, and for the first 60 ticks of a slot that sends 0.
- R5: Each slot samples the bus at tick 15. The eight samples, LSB first, form the received byte. The rx-full flag (bit 4) and bit 3 set together when the eighth slot ends. The received byte is the wired-AND of the sent byte and the device's response.
- R6: A read of address 0 returns the receive buffer and clears bit 4.
- R7: Not-busy (bit 6) is 0 while the transmit buffer or shifter holds a byte, or while `rst_busy_i` is high, and is 1 otherwise.
- R8: A pulse on `pres_done_i` sets the presence-done flag (bit 0) and copies `pres_absent_i` into bit 1 (1 = no device answered). A status read clears bit 0 and leaves bit 1 unchanged.
- R9: A pulse on `slave_low_i` sets the slave-interrupt flag (bit 5). A status read clears it.
- R10: Enable bits 6, 5, 4, 3, 2 and 0 gate status flags 6, 5, 4, 3, 2 and 0. An interrupt is pending one edge after an enabled flag newly becomes set. Enable bit 1 = 1 makes `irq_o` active-high, and 0 makes it active-low.
- R11: A status read makes `irq_o` inactive even while enabled flags stay set. It stays inactive until an enabled flag newly becomes set. Reading the data address does not clear a pending interrupt.
- R12: With enable bit 7 set, `dq_pull_o` follows `direct_low_i`, and a queued byte stays in the transmit buffer (bit 2 stays 0) until the bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle 1 MHz timing strobe |
| reg_addr_i | input | 2 | Register address: 0 data, 1 status, 2 enable |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effects at the edge) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from the address |
| pres_done_i | input | 1 | Presence check finished (pulse) |
| pres_absent_i | input | 1 | Presence result, 1 = no device |
| rst_busy_i | input | 1 | External bus reset sequence in progress |
| slave_low_i | input | 1 | Long-low detected on the bus (pulse) |
| direct_low_i | input | 1 | Bus pull level used in direct mode |
| dq_i | input | 1 | Bus level |
| dq_pull_o | output | 1 | 1 pulls the bus low |
| irq_o | output | 1 | Interrupt line, polarity set by enable bit 1 |

## Verification
Register reads are combinational, so the bench drives a read at a falling edge and samples two time units later. A flag set by a write or a strobe is visible after one rising edge. A transmit-buffer-to-shifter move takes one more edge. `irq_o` follows a newly set flag by one further edge. A byte is complete 8 × 70 ticks after its load, which the bench paces with a tick every fourth clock and waits out with margin before each check. Slot lengths are measured in ticks at the falling edges against the tick each rising edge consumed. Because of this, phase jitter between the load and the tick cannot shift the counts.

// File: rtl/owm_pkg.sv
package owm_pkg;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_EN   = 2'd2;

  localparam int EN_DIRECT = 7;
  localparam int EN_POL    = 1;
  localparam int N_IRQ     = 6;

  // interrupt-capable flags, MSB to LSB as they gate into the status word
  typedef struct packed {
    logic nbsy;
    logic sint;
    logic rbf;
    logic temt;
    logic tbe;
    logic pd;
  } irq_flags_t;
endpackage

// File: rtl/owm_slot_engine.sv
module owm_slot_engine #(
  parameter int DATA_W   = 8,
  parameter int SLOT_T   = 70,
  parameter int LOW1_T   = 6,
  parameter int LOW0_T   = 60,
  parameter int SAMPLE_T = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              dq_i,
  output logic              busy_o,
  output logic              pull_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int CNT_W = $clog2(SLOT_T + 1);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q, rx_q;
  logic [CNT_W-1:0]  low_lim;
  logic              slot_end;

  assign low_lim  = sh_q[0] ? CNT_W'(LOW1_T) : CNT_W'(LOW0_T);
  assign slot_end = active_q && tick_i && (cnt_q == CNT_W'(SLOT_T - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      idx_q    <= '0;
      sh_q     <= '0;
      rx_q     <= '0;
    end else if (start_i && !active_q) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      idx_q    <= '0;
      sh_q     <= data_i;
    end else if (active_q && tick_i) begin
      if (cnt_q == CNT_W'(SAMPLE_T)) rx_q <= {dq_i, rx_q[DATA_W-1:1]};
      if (slot_end) begin
        cnt_q <= '0;
        sh_q  <= sh_q >> 1;
        idx_q <= idx_q + 1'b1;
        if (idx_q == LAST_IDX) active_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = active_q;
  assign pull_o = active_q && (cnt_q < low_lim);
  assign done_o = slot_end && (idx_q == LAST_IDX);
  assign rx_o   = rx_q;
endmodule

// File: rtl/owm_irq_ctrl.sv
module owm_irq_ctrl #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] en_i,
  input  logic         pol_i,
  input  logic         clr_i,
  output logic         rise_o,
  output logic         irq_o
);
  logic [N-1:0] masked, masked_q;
  logic         pend_q;

  assign masked = flags_i & en_i;
  assign rise_o = |(masked & ~masked_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      masked_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      masked_q <= masked;
      pend_q   <= (pend_q && !clr_i) || rise_o;
    end
  end

  assign irq_o = pol_i ? pend_q : !pend_q;
endmodule

// File: rtl/owm_byte_engine.sv
module owm_byte_engine
  import owm_pkg::*;
#(
  parameter int SLOT_T   = 70,
  parameter int LOW1_T   = 6,
  parameter int LOW0_T   = 60,
  parameter int SAMPLE_T = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] reg_addr_i,
  input  logic       reg_wr_i,
  input  logic       reg_rd_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       pres_done_i,
  input  logic       pres_absent_i,
  input  logic       rst_busy_i,
  input  logic       slave_low_i,
  input  logic       direct_low_i,
  input  logic       dq_i,
  output logic       dq_pull_o,
  output logic       irq_o
);
  localparam int DATA_W = 8;

  logic [DATA_W-1:0] tx_buf_q, rx_buf_q, en_q, eng_rx, status;
  logic tbe_q, rbf_q, sint_q, pd_q, pdr_q;
  logic eng_busy, eng_pull, eng_done, load, nbsy, irq_rise;
  logic wr_data, wr_en, rd_data, rd_stat;
  irq_flags_t flags;

  assign wr_data = reg_wr_i && (reg_addr_i == ADDR_DATA);
  assign wr_en   = reg_wr_i && (reg_addr_i == ADDR_EN);
  assign rd_data = reg_rd_i && (reg_addr_i == ADDR_DATA);
  assign rd_stat = reg_rd_i && (reg_addr_i == ADDR_STAT);
  assign load    = !tbe_q && !eng_busy && !en_q[EN_DIRECT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_buf_q <= '0;
      rx_buf_q <= '0;
      en_q     <= '0;
      tbe_q    <= 1'b1;
      rbf_q    <= 1'b0;
      sint_q   <= 1'b0;
      pd_q     <= 1'b0;
      pdr_q    <= 1'b1;
    end else begin
      if (wr_data) tx_buf_q <= reg_wdata_i;
      if (wr_en)   en_q     <= reg_wdata_i;
      if (wr_data)   tbe_q <= 1'b0;
      else if (load) tbe_q <= 1'b1;
      // set beats the read clear so an event is never lost
      if (eng_done) begin
        rx_buf_q <= eng_rx;
        rbf_q    <= 1'b1;
      end else if (rd_data) begin
        rbf_q    <= 1'b0;
      end
      if (slave_low_i)  sint_q <= 1'b1;
      else if (rd_stat) sint_q <= 1'b0;
      if (pres_done_i) begin
        pd_q  <= 1'b1;
        pdr_q <= pres_absent_i;
      end else if (rd_stat) begin
        pd_q  <= 1'b0;
      end
    end
  end

  owm_slot_engine #(
    .DATA_W(DATA_W), .SLOT_T(SLOT_T), .LOW1_T(LOW1_T),
    .LOW0_T(LOW0_T), .SAMPLE_T(SAMPLE_T)
  ) u_slot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .start_i(load),
    .data_i (tx_buf_q),
    .dq_i   (dq_i),
    .busy_o (eng_busy),
    .pull_o (eng_pull),
    .done_o (eng_done),
    .rx_o   (eng_rx)
  );

  assign nbsy = !(eng_busy || !tbe_q || rst_busy_i);

  assign flags = '{nbsy: nbsy, sint: sint_q, rbf: rbf_q,
                   temt: !eng_busy, tbe: tbe_q, pd: pd_q};

  owm_irq_ctrl #(.N(N_IRQ)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flags_i(flags),
    .en_i   ({en_q[6:2], en_q[0]}),
    .pol_i  (en_q[EN_POL]),
    .clr_i  (rd_stat),
    .rise_o (irq_rise),
    .irq_o  (irq_o)
  );

  assign status = {dq_i, nbsy, sint_q, rbf_q, !eng_busy, tbe_q, pdr_q, pd_q};

  always_comb begin
    unique case (reg_addr_i)
      ADDR_DATA: reg_rdata_o = rx_buf_q;
      ADDR_STAT: reg_rdata_o = status;
      ADDR_EN:   reg_rdata_o = en_q;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign dq_pull_o = en_q[EN_DIRECT] ? direct_low_i : eng_pull;
endmodule

// File: rtl/owm_byte_engine_chk.sv
module owm_byte_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] reg_addr_i,
  input logic       reg_wr_i,
  input logic       reg_rd_i,
  input logic       pres_done_i,
  input logic       slave_low_i,
  input logic       tbe_q,
  input logic       rbf_q,
  input logic       pd_q,
  input logic       sint_q,
  input logic       eng_busy,
  input logic       irq_rise,
  input logic       irq_pol,
  input logic       irq_o
);
  a_r2_write_clears_tbe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 2'd0) |=> !tbe_q);

  a_r6_read_clears_rbf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == 2'd0 && !eng_busy) |=> !rbf_q);

  a_r8_presence_sets_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pres_done_i |=> pd_q);

  a_r9_slave_sets_sint: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_low_i |=> sint_q);

  a_r11_read_drops_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == 2'd1 && !irq_rise && !reg_wr_i) |=> (irq_o == !irq_pol));
endmodule

bind owm_byte_engine owm_byte_engine_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_addr_i (reg_addr_i),
  .reg_wr_i   (reg_wr_i),
  .reg_rd_i   (reg_rd_i),
  .pres_done_i(pres_done_i),
  .slave_low_i(slave_low_i),
  .tbe_q      (tbe_q),
  .rbf_q      (rbf_q),
  .pd_q       (pd_q),
  .sint_q     (sint_q),
  .eng_busy   (eng_busy),
  .irq_rise   (irq_rise),
  .irq_pol    (en_q[1]),
  .irq_o      (irq_o)
);

// File: tb/owm_byte_engine_test.sv
`timescale 1ns/1ps
module owm_byte_engine_test;
  localparam int BYTE_WAIT = 2300;
  // {tx byte, device response, expected rx}
  localparam logic [23:0] VEC [6] = '{
    24'hFF_A5_A5, 24'hFF_3C_3C, 24'h5A_FF_5A,
    24'h0F_F0_00, 24'hFF_FF_FF, 24'hC3_81_81
  };

  logic clk = 0, rst_n = 0, tick = 0;
  logic [1:0] addr = 0;
  logic wr = 0, rd = 0;
  logic [7:0] wdata = 0, rdata;
  logic pres_done = 0, pres_absent = 0, rst_busy = 0, slave_pulse = 0, direct_low = 0;
  logic force_low = 0, sl_low = 0, pull, irq, dq;

  int checks = 0, errors = 0;
  int div = 0, tick_acc = 0, low_acc = 0, slot_i = 0;
  int low_len [16];
  int per [16];
  logic pull_prev = 0;
  logic [7:0] resp = 8'hFF;
  int sl_idx = 0, sl_cnt = 0;
  logic sl_active = 0, sl_bit = 1;

  assign dq = !(pull || sl_low || force_low);

  owm_byte_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pres_done_i(pres_done), .pres_absent_i(pres_absent),
    .rst_busy_i(rst_busy), .slave_low_i(slave_pulse),
    .direct_low_i(direct_low), .dq_i(dq), .dq_pull_o(pull), .irq_o(irq)
  );

  always #10 clk = !clk;

  // tick generator, slot monitor and device model
  always @(negedge clk) begin
    if (tick) begin
      tick_acc++;
      if (pull_prev) low_acc++;
      if (sl_active) sl_cnt++;
    end
    if (pull && !pull_prev) begin
      if (slot_i > 0 && slot_i <= 16) per[slot_i-1] = tick_acc;
      tick_acc = 0;
      sl_active = 1;
      sl_bit = resp[sl_idx % 8];
      sl_idx++;
      sl_cnt = 0;
    end
    if (!pull && pull_prev) begin
      if (slot_i < 16) low_len[slot_i] = low_acc;
      low_acc = 0;
      slot_i++;
    end
    if (sl_cnt >= 40) sl_active = 0;
    sl_low = sl_active && !sl_bit && (sl_cnt < 30);
    pull_prev = pull;
    tick = (div == 3);
    div = (div + 1) % 4;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1;
    #2 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) pres_done = 1; else slave_pulse = 1;
    @(negedge clk); pres_done = 0; slave_pulse = 0;
  endtask

  initial begin
    logic [7:0] v;
    force_low = 1;
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(1);
    chk("R1 irq idle", 8'(irq), 8'h01);
    reg_rd(1, v); chk("R1 status", v, 8'h4E);
    reg_rd(2, v); chk("R1 enable", v, 8'h00);
    force_low = 0;

    // slot timing: bit0 = 1, bit1 = 0
    slot_i = 0; resp = 8'hFF; sl_idx = 0;
    reg_wr(0, 8'h01);
    reg_rd(1, v); chk("R2 tbe set temt clear", v & 8'h0C, 8'h04);
    wait_cyc(BYTE_WAIT);
    chk("R4 low ticks bit 1", 8'(low_len[0]), 8'd6);
    chk("R4 low ticks bit 0", 8'(low_len[1]), 8'd60);
    chk("R4 slot ticks", 8'(per[0]), 8'd70);
    chk("R4 slot ticks late", 8'(per[6]), 8'd70);
    reg_rd(0, v); chk("R5 rx of 01", v, 8'h01);

    // vector table: send / respond / expect
    foreach (VEC[i]) begin
      resp = VEC[i][15:8]; sl_idx = 0;
      reg_wr(0, VEC[i][23:16]);
      wait_cyc(BYTE_WAIT);
      reg_rd(1, v); chk("R5 rbf temt tbe nbsy set", v & 8'h5C, 8'h5C);
      reg_rd(0, v); chk("R5 R6 rx byte", v, VEC[i][7:0]);
      reg_rd(1, v); chk("R6 rbf cleared", v & 8'h10, 8'h00);
    end
    resp = 8'hFF;

    // back-to-back bytes
    sl_idx = 0;
    reg_wr(0, 8'hFF);
    reg_wr(0, 8'h00);
    reg_rd(1, v); chk("R3 R7 queued while busy", v & 8'h4C, 8'h00);
    wait_cyc(BYTE_WAIT);
    reg_rd(1, v); chk("R3 second byte loaded", v & 8'h1C, 8'h14);
    reg_rd(0, v); chk("R3 first rx", v, 8'hFF);
    wait_cyc(BYTE_WAIT);
    reg_rd(0, v); chk("R3 second rx", v, 8'h00);

    // external reset busy
    rst_busy = 1;
    reg_rd(1, v); chk("R7 busy from reset", v & 8'h40, 8'h00);
    rst_busy = 0;
    reg_rd(1, v); chk("R7 idle", v & 8'h40, 8'h40);

    // presence and slave interrupt
    pres_absent = 0; pulse(0);
    reg_rd(1, v); chk("R8 presence found", v & 8'h03, 8'h01);
    reg_rd(1, v); chk("R8 pd cleared", v & 8'h03, 8'h00);
    pres_absent = 1; pulse(0);
    reg_rd(1, v); chk("R8 presence absent", v & 8'h03, 8'h03);
    pulse(1);
    reg_rd(1, v); chk("R9 sint set", v & 8'h20, 8'h20);
    reg_rd(1, v); chk("R9 sint cleared", v & 8'h20, 8'h00);

    // direct mode
    reg_wr(2, 8'h80);
    reg_wr(0, 8'h55);
    wait_cyc(10);
    reg_rd(1, v); chk("R12 byte held", v & 8'h0C, 8'h08);
    @(negedge clk); direct_low = 1; #2 chk("R12 direct low", 8'(pull), 8'h01);
    @(negedge clk); direct_low = 0; #2 chk("R12 direct release", 8'(pull), 8'h00);
    reg_wr(2, 8'h00);
    wait_cyc(2);
    reg_rd(1, v); chk("R12 byte loads after exit", v & 8'h0C, 8'h04);
    wait_cyc(BYTE_WAIT);
    reg_rd(0, v); chk("R12 rx after exit", v, 8'h55);

    // interrupt enables and polarity
    reg_wr(2, 8'h08);
    wait_cyc(2);
    chk("R10 temt enabled active-low", 8'(irq), 8'h00);
    reg_rd(1, v);
    wait_cyc(1);
    chk("R11 read drops irq", 8'(irq), 8'h01);
    wait_cyc(10);
    chk("R11 stays inactive with flag set", 8'(irq), 8'h01);
    reg_wr(2, 8'h12);
    wait_cyc(2);
    chk("R10 active-high idle", 8'(irq), 8'h00);
    reg_wr(0, 8'hFF);
    wait_cyc(BYTE_WAIT);
    chk("R10 rbf raises irq", 8'(irq), 8'h01);
    reg_rd(0, v);
    wait_cyc(1);
    chk("R11 data read keeps irq", 8'(irq), 8'h01);
    reg_rd(1, v);
    wait_cyc(1);
    chk("R11 status read drops irq", 8'(irq), 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(190000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule